// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a small 32-bit integer processor that completes one instruction on every clock. In a single cycle it fetches a word from its own instruction port, splits the word into fields, reads two source registers, computes a result, optionally reads or writes one word through a separate data port, writes the result back and selects the next program counter. Because instruction fetch and data access use two different ports, a load or store never stalls the fetch.

The supported operations are word load and store, add-immediate, shift-left by a constant, register add, two conditional branches (equal, and less-than-or-equal-to-zero), absolute jump with and without link, and register jump with and without link. Every other encoding is reported on an illegal flag and executed as a no-op. Both memory ports are read combinationally within the cycle, and the data port write takes effect at the clock edge that ends the cycle. Memory is byte-addressed and big-endian, and only whole words are moved.

Top module: `mini_core`

## Requirements
- R1: A synchronous reset loads the program counter with 0x0000_0000 and clears every register, so the first fetch after reset is from address 0 and every register reads 0 until written.
- R2: Register 0 always reads as 0; any result aimed at it is discarded.
- R3: With opcode 0x00, funct 0x21 writes rs + rt (modulo 2^32) to rd, and funct 0x00 writes rt shifted left by shamt (bits 10:6) to rd.
- R4: Opcode 0x09 writes rs plus the sign-extended immediate (bits 15:0) to rt.
- R5: Opcode 0x23 drives the data address rs + sign-extended immediate and writes the word read back to rt in the same cycle.
- R6: Opcode 0x2B drives the data address rs + sign-extended immediate, the write data rt, and raises the write enable for that one cycle only; no register changes.
- R7: Opcode 0x04 branches when rs equals rt to PC + 4 + (sign-extended immediate × 4); otherwise the next PC is PC + 4.
- R8: Opcode 0x06 branches to the same kind of target when rs, read as a signed value, is zero or negative; otherwise the next PC is PC + 4.
- R9: Opcode 0x02 jumps to {upper 4 bits of PC + 4, target bits 25:0, 00}; opcode 0x03 does the same and also writes PC + 4 to register 31.
- R10: With opcode 0x00, funct 0x08 sets the next PC to rs, and funct 0x09 sets the next PC to rs and writes PC + 4 to rd, using the value of rs from before the write.
- R11: Any other opcode, or any other funct under opcode 0x00, raises the illegal flag for that cycle, writes no register, does not write memory, and continues at PC + 4.
- R12: Exactly one instruction completes per clock: the fetch address moves to the next PC at every edge outside reset, while the data port is used in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_rdata | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the data word for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, the word is written at the next rising edge |
| dmem_rdata | input | 32 | Data word at dmem_addr, valid in the same cycle |
| illegal | output | 1 | High while an unsupported instruction is being executed |

## Verification
A directed prologue feeds the boundary patterns: an add that wraps to zero, a shift by 31, a write aimed at register 0, branch-on-less-or-equal with zero, negative and positive operands, equal and unequal compares, each jump form, and three kinds of illegal word; these separate signed from unsigned compares, taken from not-taken paths and link writes from plain jumps. A seeded random section then mixes arithmetic with random immediates, loads and stores at random offsets, forward branches with equal and unequal operands and register jumps to computed addresses, which tells apart register forwarding errors and wrong destination fields. Every cycle the fetch address, store strobe, data address and store data are compared with a model in the bench, and a final dump of all registers to memory exposes the register file contents.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned REG_COUNT = 1 << REG_IDX_W;
    localparam int unsigned OPC_W     = 6;

    // Major opcodes (bits 31:26)
    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0] OPC_J       = 6'h02;
    localparam logic [OPC_W-1:0] OPC_JAL     = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BEQ     = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BLEZ    = 6'h06;
    localparam logic [OPC_W-1:0] OPC_ADDIU   = 6'h09;
    localparam logic [OPC_W-1:0] OPC_LW      = 6'h23;
    localparam logic [OPC_W-1:0] OPC_SW      = 6'h2B;

    // Function codes under OPC_SPECIAL (bits 5:0)
    localparam logic [OPC_W-1:0] FN_SLL  = 6'h00;
    localparam logic [OPC_W-1:0] FN_JR   = 6'h08;
    localparam logic [OPC_W-1:0] FN_JALR = 6'h09;
    localparam logic [OPC_W-1:0] FN_ADDU = 6'h21;

    localparam logic [REG_IDX_W-1:0] LINK_REG = 5'd31;

    typedef enum logic [3:0] {
        K_ADDU,
        K_SLL,
        K_ADDIU,
        K_LW,
        K_SW,
        K_BEQ,
        K_BLEZ,
        K_J,
        K_JAL,
        K_JR,
        K_JALR,
        K_ILLEGAL
    } op_kind_e;

endpackage

// File: rtl/core_regfile.sv
module core_regfile #(
    parameter int unsigned REG_COUNT = 32,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned IDX_W    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic              w_en,
    input  logic [DATA_W-1:0] w_data,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data
);

    logic [DATA_W-1:0] bank [REG_COUNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_COUNT; i++) begin
                bank[i] <= '0;
            end
        end else if (w_en && (w_idx != '0)) begin
            bank[w_idx] <= w_data;
        end
    end

    // Entry zero is never written; the compare keeps it at zero regardless.
    always_comb begin
        ra_data = (ra_idx == '0) ? '0 : bank[ra_idx];
        rb_data = (rb_idx == '0) ? '0 : bank[rb_idx];
    end

endmodule

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [WORD_W-1:0]    instr,
    output op_kind_e             kind,
    output logic [REG_IDX_W-1:0] rs_idx,
    output logic [REG_IDX_W-1:0] rt_idx,
    output logic [REG_IDX_W-1:0] wr_idx,
    output logic                 wr_en,
    output logic [WORD_W-1:0]    imm,
    output logic [4:0]           shamt,
    output logic [25:0]          jtgt
);

    logic [OPC_W-1:0]     opcode;
    logic [OPC_W-1:0]     funct;
    logic [REG_IDX_W-1:0] rd_idx;

    always_comb begin
        opcode = instr[31:26];
        funct  = instr[5:0];
        rd_idx = instr[15:11];
        rs_idx = instr[25:21];
        rt_idx = instr[20:16];
        shamt  = instr[10:6];
        jtgt   = instr[25:0];
        imm    = {{(WORD_W-16){instr[15]}}, instr[15:0]};
    end

    always_comb begin
        kind = K_ILLEGAL;
        unique case (opcode)
            OPC_SPECIAL: begin
                unique case (funct)
                    FN_SLL:  kind = K_SLL;
                    FN_ADDU: kind = K_ADDU;
                    FN_JR:   kind = K_JR;
                    FN_JALR: kind = K_JALR;
                    default: kind = K_ILLEGAL;
                endcase
            end
            OPC_J:     kind = K_J;
            OPC_JAL:   kind = K_JAL;
            OPC_BEQ:   kind = K_BEQ;
            OPC_BLEZ:  kind = K_BLEZ;
            OPC_ADDIU: kind = K_ADDIU;
            OPC_LW:    kind = K_LW;
            OPC_SW:    kind = K_SW;
            default:   kind = K_ILLEGAL;
        endcase
    end

    // Destination selection: R-form to rd, I-form to rt, link jump to r31.
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = '0;
        unique case (kind)
            K_ADDU, K_SLL, K_JALR: begin
                wr_en  = 1'b1;
                wr_idx = rd_idx;
            end
            K_ADDIU, K_LW: begin
                wr_en  = 1'b1;
                wr_idx = rt_idx;
            end
            K_JAL: begin
                wr_en  = 1'b1;
                wr_idx = LINK_REG;
            end
            default: begin
                wr_en  = 1'b0;
                wr_idx = '0;
            end
        endcase
    end

endmodule

// File: rtl/core_exec.sv
module core_exec
    import core_pkg::*;
(
    input  op_kind_e          kind,
    input  logic [WORD_W-1:0] pc,
    input  logic [WORD_W-1:0] rs_val,
    input  logic [WORD_W-1:0] rt_val,
    input  logic [WORD_W-1:0] imm,
    input  logic [WORD_W-1:0] load_data,
    input  logic [4:0]        shamt,
    input  logic [25:0]       jtgt,
    output logic [WORD_W-1:0] next_pc,
    output logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] mem_addr,
    output logic              mem_we
);

    logic [WORD_W-1:0] pc_plus4;
    logic [WORD_W-1:0] branch_tgt;
    logic [WORD_W-1:0] jump_tgt;
    logic [WORD_W-1:0] sum_imm;

    always_comb begin
        pc_plus4   = pc + WORD_W'(4);
        branch_tgt = pc_plus4 + (imm << 2);
        jump_tgt   = {pc_plus4[WORD_W-1:28], jtgt, 2'b00};
        sum_imm    = rs_val + imm;
        mem_addr   = sum_imm;
    end

    always_comb begin
        next_pc = pc_plus4;
        wr_data = sum_imm;
        mem_we  = 1'b0;
        unique case (kind)
            K_ADDU:  wr_data = rs_val + rt_val;
            K_SLL:   wr_data = rt_val << shamt;
            K_ADDIU: wr_data = sum_imm;
            K_LW:    wr_data = load_data;
            K_SW:    mem_we  = 1'b1;
            K_BEQ: begin
                if (rs_val == rt_val) next_pc = branch_tgt;
            end
            K_BLEZ: begin
                if ($signed(rs_val) <= 0) next_pc = branch_tgt;
            end
            K_J:     next_pc = jump_tgt;
            K_JAL: begin
                next_pc = jump_tgt;
                wr_data = pc_plus4;
            end
            K_JR:    next_pc = rs_val;
            K_JALR: begin
                next_pc = rs_val;
                wr_data = pc_plus4;
            end
            default: begin
                next_pc = pc_plus4;
            end
        endcase
    end

endmodule

// File: rtl/mini_core.sv
module mini_core
    import core_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic [WORD_W-1:0] dmem_addr,
    output logic [WORD_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [WORD_W-1:0] dmem_rdata,
    output logic              illegal
);

    logic [WORD_W-1:0]    pc_q;
    op_kind_e             kind;
    logic [REG_IDX_W-1:0] rs_idx;
    logic [REG_IDX_W-1:0] rt_idx;
    logic [REG_IDX_W-1:0] wr_idx;
    logic                 wr_en;
    logic [WORD_W-1:0]    imm;
    logic [4:0]           shamt;
    logic [25:0]          jtgt;
    logic [WORD_W-1:0]    rs_val;
    logic [WORD_W-1:0]    rt_val;
    logic [WORD_W-1:0]    next_pc;
    logic [WORD_W-1:0]    wr_data;
    logic [WORD_W-1:0]    mem_addr;
    logic                 mem_we;
    logic                 rf_we;

    core_decode u_decode (
        .instr  (imem_rdata),
        .kind   (kind),
        .rs_idx (rs_idx),
        .rt_idx (rt_idx),
        .wr_idx (wr_idx),
        .wr_en  (wr_en),
        .imm    (imm),
        .shamt  (shamt),
        .jtgt   (jtgt)
    );

    core_regfile #(
        .REG_COUNT (REG_COUNT),
        .DATA_W    (WORD_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (rs_idx),
        .rb_idx  (rt_idx),
        .w_idx   (wr_idx),
        .w_en    (rf_we),
        .w_data  (wr_data),
        .ra_data (rs_val),
        .rb_data (rt_val)
    );

    core_exec u_exec (
        .kind      (kind),
        .pc        (pc_q),
        .rs_val    (rs_val),
        .rt_val    (rt_val),
        .imm       (imm),
        .load_data (dmem_rdata),
        .shamt     (shamt),
        .jtgt      (jtgt),
        .next_pc   (next_pc),
        .wr_data   (wr_data),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we)
    );

    // Program counter register
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= next_pc;
        end
    end

    // Outputs and commit strobes, held off while reset is applied
    always_comb begin
        imem_addr  = pc_q;
        dmem_addr  = mem_addr;
        dmem_wdata = rt_val;
        dmem_we    = mem_we & ~rst;
        illegal    = (kind == K_ILLEGAL) & ~rst;
        rf_we      = wr_en & ~rst;
    end

endmodule

// File: rtl/core_checks.sv
module core_checks #(
    parameter logic [31:0] RESET_PC = '0
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] imem_addr,
    input logic [5:0]  opcode,
    input logic        dmem_we,
    input logic        illegal,
    input logic        rf_we,
    input logic [4:0]  rs_idx,
    input logic [31:0] rs_val
);

    // R1: first fetch after reset comes from the reset address
    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (imem_addr == RESET_PC));

    // R2: register zero reads zero on the source port
    assert_zero_reg_R2: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == 5'd0) |-> (rs_val == 32'd0));

    // R11: an illegal word commits nothing
    assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!rf_we && !dmem_we));

    // R11: an illegal word falls through to the next sequential address
    assert_illegal_advance_R11: assert property (@(posedge clk) disable iff (rst)
        illegal |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R6: the store strobe only accompanies the store opcode
    assert_store_only_R6: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (opcode == 6'h2B));

endmodule

bind mini_core core_checks #(.RESET_PC(RESET_PC)) u_core_checks (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .opcode    (imem_rdata[31:26]),
    .dmem_we   (dmem_we),
    .illegal   (illegal),
    .rf_we     (rf_we),
    .rs_idx    (rs_idx),
    .rs_val    (rs_val)
);

// File: tb/test_mini_core.sv
module test_mini_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, illegal;

    always #10 clk = ~clk;   // 50 MHz

    logic [31:0] im [0:511];
    logic [31:0] dm [0:255];

    assign imem_rdata = im[imem_addr[10:2]];
    assign dmem_rdata = dm[dmem_addr[9:2]];
    always @(posedge clk) if (dmem_we) dm[dmem_addr[9:2]] <= dmem_wdata;

    mini_core i_mini_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata),
        .illegal    (illegal)
    );

    // Reference state
    logic [31:0] m_pc;
    logic [31:0] m_rf [0:31];
    logic [31:0] m_dm [0:255];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          wp      = 0;
    string       pc_tag  = "R1";

    localparam logic [31:0] FILLER  = {6'h09, 5'd0, 5'd5, 16'h5555};
    localparam logic [31:0] BAD_OPC = 32'hFC00_0000;

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] im16);
        return {op, rs, rt, im16};
    endfunction

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [4:0] sh, logic [5:0] fn);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, int word_idx);
        return {op, 26'(word_idx)};
    endfunction

    function automatic logic [4:0] rreg();
        return 5'($urandom % 32);
    endfunction

    task automatic emit(logic [31:0] w);
        im[wp] = w;
        wp++;
    endtask

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // One model step: compare this cycle's outputs, then advance the model.
    task automatic step_model();
        logic [31:0] ins, rsv, rtv, sext, npc, addr, wval;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, sh, widx;
        logic        e_we, e_ill, wr, is_ld;
        string       tag;
        ins  = im[m_pc[10:2]];
        op   = ins[31:26]; fn = ins[5:0];
        rs   = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; sh = ins[10:6];
        rsv  = m_rf[rs];   rtv = m_rf[rt];
        sext = {{16{ins[15]}}, ins[15:0]};
        addr = rsv + sext;
        npc  = m_pc + 32'd4;
        e_we = 1'b0; e_ill = 1'b0; wr = 1'b0; is_ld = 1'b0;
        widx = 5'd0; wval = 32'd0; tag = "R12";
        case (op)
            6'h00: case (fn)
                6'h00: begin wr = 1'b1; widx = rd; wval = rtv << sh; tag = "R3"; end
                6'h21: begin wr = 1'b1; widx = rd; wval = rsv + rtv; tag = "R3"; end
                6'h08: begin npc = rsv; tag = "R10"; end
                6'h09: begin npc = rsv; wr = 1'b1; widx = rd; wval = m_pc + 32'd4; tag = "R10"; end
                default: begin e_ill = 1'b1; tag = "R11"; end
            endcase
            6'h09: begin wr = 1'b1; widx = rt; wval = addr; tag = "R4"; end
            6'h23: begin wr = 1'b1; widx = rt; wval = m_dm[addr[9:2]]; is_ld = 1'b1; tag = "R5"; end
            6'h2B: begin e_we = 1'b1; tag = "R6"; end
            6'h04: begin if (rsv == rtv) npc = m_pc + 32'd4 + (sext << 2); tag = "R7"; end
            6'h06: begin if ($signed(rsv) <= 0) npc = m_pc + 32'd4 + (sext << 2); tag = "R8"; end
            6'h02: begin npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R9"; end
            6'h03: begin wr = 1'b1; widx = 5'd31; wval = m_pc + 32'd4;
                         npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R9"; end
            default: begin e_ill = 1'b1; tag = "R11"; end
        endcase
        chk(tag, "illegal", 32'(illegal), 32'(e_ill));
        chk(tag, "dmem_we", 32'(dmem_we), 32'(e_we));
        if (is_ld) chk("R5", "load address", dmem_addr, addr);
        if (e_we) begin
            chk("R6", "store address", dmem_addr, addr);
            chk("R6", "store data", dmem_wdata, rtv);
            m_dm[addr[9:2]] = rtv;
        end
        if (wr && widx != 5'd0) m_rf[widx] = wval;
        m_pc   = npc;
        pc_tag = (tag == "R3" || tag == "R4" || tag == "R5" || tag == "R6") ? "R12" : tag;
    endtask

    task automatic build_program();
        int p;
        for (int i = 0; i < 512; i++) im[i] = BAD_OPC;
        // Directed prologue
        emit(enc_i(6'h2B, 5'd0, 5'd7, 16'h01F0));      // store untouched r7 (R1)
        emit(enc_i(6'h09, 5'd0, 5'd1, 16'hFFFF));      // r1 = -1 (R4)
        emit(enc_i(6'h09, 5'd0, 5'd2, 16'h0001));      // r2 = 1
        emit(enc_r(5'd1, 5'd2, 5'd3, 5'd0, 6'h21));    // r3 = 0 by wrap (R3)
        emit(enc_r(5'd0, 5'd2, 5'd4, 5'd31, 6'h00));   // r4 = 0x8000_0000 (R3)
        emit(enc_r(5'd1, 5'd1, 5'd0, 5'd0, 6'h21));    // write to r0 dropped (R2)
        emit(enc_i(6'h2B, 5'd0, 5'd0, 16'h01F4));      // store r0 (R2)
        emit(enc_i(6'h06, 5'd3, 5'd0, 16'h0001));      // zero: taken (R8)
        emit(FILLER);
        emit(enc_i(6'h06, 5'd4, 5'd0, 16'h0001));      // negative: taken (R8)
        emit(FILLER);
        emit(enc_i(6'h06, 5'd2, 5'd0, 16'h0001));      // positive: not taken (R8)
        emit(enc_i(6'h04, 5'd1, 5'd2, 16'h0001));      // unequal: not taken (R7)
        emit(enc_i(6'h04, 5'd1, 5'd1, 16'h0001));      // equal: taken (R7)
        emit(FILLER);
        p = wp; emit(enc_j(6'h02, p + 2)); emit(FILLER);              // R9
        p = wp; emit(enc_j(6'h03, p + 2)); emit(FILLER);              // R9 link
        p = wp; emit(enc_i(6'h09, 5'd0, 5'd6, 16'((p + 3) * 4)));
        emit(enc_r(5'd6, 5'd0, 5'd0, 5'd0, 6'h08)); emit(FILLER);     // R10
        p = wp; emit(enc_i(6'h09, 5'd0, 5'd8, 16'((p + 3) * 4)));
        emit(enc_r(5'd8, 5'd0, 5'd8, 5'd0, 6'h09)); emit(FILLER);     // R10, rd == rs
        emit(BAD_OPC);                                                // R11
        emit(enc_r(5'd1, 5'd2, 5'd10, 5'd0, 6'h20));                  // R11 bad funct
        emit(enc_i(6'h08, 5'd1, 5'd11, 16'h0004));                    // R11 bad opcode
        emit(enc_i(6'h23, 5'd0, 5'd12, 16'h0010));                    // R5
        emit(enc_i(6'h2B, 5'd0, 5'd12, 16'h0014));                    // R6
        // Seeded random body
        for (int k = 0; k < 120; k++) begin
            int sel;
            sel = int'($urandom % 12);
            case (sel)
                0, 1, 2: emit(enc_i(6'h09, rreg(), rreg(), 16'($urandom)));
                3:  emit(enc_r(rreg(), rreg(), rreg(), 5'd0, 6'h21));
                4:  emit(enc_r(5'd0, rreg(), rreg(), 5'($urandom), 6'h00));
                5:  emit(enc_i(6'h23, 5'd0, rreg(), 16'(($urandom % 128) * 4)));
                6:  emit(enc_i(6'h2B, 5'd0, rreg(), 16'(($urandom % 128) * 4)));
                7: begin
                    logic [4:0] a;
                    a = rreg();
                    emit(enc_i(6'h04, a, ($urandom % 2 == 0) ? a : rreg(), 16'($urandom % 3)));
                end
                8:  emit(enc_i(6'h06, rreg(), 5'd0, 16'($urandom % 3)));
                9: begin
                    p = wp;
                    emit(enc_j(($urandom % 2 == 0) ? 6'h02 : 6'h03, p + 1 + int'($urandom % 3)));
                end
                10: begin
                    logic [4:0] rx;
                    rx = 5'(1 + ($urandom % 31));
                    p = wp;
                    emit(enc_i(6'h09, 5'd0, rx, 16'((p + 3) * 4)));
                    if ($urandom % 2 == 0) emit(enc_r(rx, 5'd0, 5'd0, 5'd0, 6'h08));
                    else                   emit(enc_r(rx, 5'd0, rreg(), 5'd0, 6'h09));
                    emit(FILLER);
                end
                default: begin
                    case ($urandom % 3)
                        0: emit(BAD_OPC);
                        1: emit(enc_r(rreg(), rreg(), rreg(), 5'd0, 6'h20));
                        default: emit(enc_i(6'h08, rreg(), rreg(), 16'($urandom)));
                    endcase
                end
            endcase
        end
        // Dump every register, then spin in place
        for (int r = 0; r < 32; r++) emit(enc_i(6'h2B, 5'd0, 5'(r), 16'(32'h200 + r * 4)));
        emit(enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));
    endtask

    initial begin
        int          cycles;
        int          spin;
        logic [31:0] loop_addr;
        void'($urandom(32'd20250117));
        for (int i = 0; i < 256; i++) begin
            dm[i]   = $urandom;
            m_dm[i] = dm[i];
        end
        for (int r = 0; r < 32; r++) m_rf[r] = 32'd0;
        build_program();
        loop_addr = 32'((wp - 1) * 4);
        m_pc = 32'd0;

        repeat (3) @(negedge clk);
        chk("R1", "store strobe in reset", 32'(dmem_we), 32'd0);
        rst = 1'b0;
        #1;
        chk("R1", "fetch address after reset", imem_addr, 32'd0);
        chk("R1", "cleared register on store data", dmem_wdata, 32'd0);

        cycles = 0;
        spin   = 0;
        while (spin < 3 && cycles < 4000) begin
            chk(pc_tag, "fetch address", imem_addr, m_pc);
            step_model();
            if (m_pc == loop_addr) spin++;
            @(negedge clk);
            #1;
            cycles++;
        end
        if (cycles >= 4000) begin
            n_tests++;
            n_fail++;
            $display("FAIL R12 watchdog: got %0d cycles expected fewer than 4000", cycles);
        end

        for (int i = 0; i < 256; i++) begin
            chk((i == 128) ? "R2" : "R6", "data word", dm[i], m_dm[i]);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule